// File: doc/BRIEF.md
# AC-Drive Segment Driver for a 3-1/2 Digit Static Display

This block turns a latched sign-and-magnitude BCD reading into the drive lines of a 3-1/2 digit static liquid crystal display. The hundreds, tens and units digits are each decoded to seven segments. The leading half digit is one line that can only show "1". The minus sign is a single line. A free-running divider builds a square-wave backplane from the system clock. Each segment line is either that backplane (segment dark) or its inverse (segment lit), so in normal use the glass sees no DC level.

A measurement engine presents a new reading together with a one-cycle load strobe. Until the next strobe the display keeps showing the held reading. Leading zeros in the hundreds and tens positions are blanked. An overrange flag shows only the leading "1" and the sign. A lamp-test input forces every segment line to a constant high level for a visual check.

Top module: `lcd_ac_driver`

## Requirements
- R1: `backplane` is low during and right after reset and toggles on every BP_HALF-th rising clock edge after reset is released (default 400, so the period is 800 clocks, 50% duty). After n non-reset edges its level is floor(n / BP_HALF) mod 2.
- R2: Outside lamp test, a dark segment line equals `backplane` and a lit segment line equals its inverse.
- R3: Each seven-segment field maps bit 0 to segment a through bit 6 to segment g. Digits 0 to 9 use the standard font (hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F). Codes 10 to 15 light nothing.
- R4: The hundreds digit is blank when the half-digit bit and the hundreds code are both zero. The tens digit is blank when, in addition, the tens code is zero. The units digit is always shown.
- R5: Without overrange, `seg_lead` is lit exactly when the latched half-digit bit is 1.
- R6: `seg_minus` is lit exactly when the latched sign bit is 1, with or without overrange.
- R7: With the latched overrange flag set, `seg_lead` is lit and all three seven-segment digits are blank.
- R8: The reading inputs are captured only on a rising edge where `load` is 1, and the new reading appears right after that edge. Input changes without `load` have no effect on the display.
- R9: While `lamp_test` is 1, all 23 segment lines are held constantly high in the same cycle, and `backplane` keeps running. When the test ends, the held reading returns.
- R10: Reset clears the held reading to positive, in range, all digits zero, so only the units "0" is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures the reading inputs on this edge |
| dig_units | input | 4 | Units BCD code |
| dig_tens | input | 4 | Tens BCD code |
| dig_hund | input | 4 | Hundreds BCD code |
| half_one | input | 1 | Leading half digit is "1" |
| negative | input | 1 | Reading is negative |
| overrange | input | 1 | Reading exceeds full scale |
| lamp_test | input | 1 | Force all segment lines high |
| seg_units | output | 7 | Units segments a..g (bit 0 = a) |
| seg_tens | output | 7 | Tens segments a..g |
| seg_hund | output | 7 | Hundreds segments a..g |
| seg_lead | output | 1 | Leading "1" (both halves) |
| seg_minus | output | 1 | Minus sign |
| backplane | output | 1 | Common backplane square wave |

## Verification
A divider that slips or sticks shows at the ports as a backplane edge arriving early, late or never. All segment lines follow it, so the error is visible within one half period. A wrong held reading or blanking decision shows as soon as the segment lines are compared with the inverse of the backplane. The XOR with the backplane does not hide it, because the lit/dark pattern is recovered in every cycle. A load capture that is missing or spurious changes that pattern in the cycle right after the edge in question.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int SEG_W  = 7;
    localparam int LINE_N = 3 * SEG_W + 2;

    typedef logic [SEG_W-1:0] seg7_t;

    typedef struct packed {
        logic [3:0] hund;
        logic [3:0] tens;
        logic [3:0] units;
        logic       half;
        logic       neg;
        logic       over;
    } reading_t;

    typedef struct packed {
        seg7_t hund;
        seg7_t tens;
        seg7_t units;
        logic  lead;
        logic  minus;
    } seg_en_t;

    // bit 0 = a ... bit 6 = g
    function automatic seg7_t seg7_font(input logic [3:0] code);
        seg7_t f;
        case (code)
            4'd0:    f = 7'h3F;
            4'd1:    f = 7'h06;
            4'd2:    f = 7'h5B;
            4'd3:    f = 7'h4F;
            4'd4:    f = 7'h66;
            4'd5:    f = 7'h6D;
            4'd6:    f = 7'h7D;
            4'd7:    f = 7'h07;
            4'd8:    f = 7'h7F;
            4'd9:    f = 7'h6F;
            default: f = 7'h00;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
    parameter int BP_HALF = 400
) (
    input  logic clk,
    input  logic rst,
    output logic bp
);
    localparam int CW = (BP_HALF > 1) ? $clog2(BP_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(BP_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_reading_reg.sv
module lcd_reading_reg
    import lcd_drv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  reading_t d,
    output reading_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
    import lcd_drv_pkg::*;
(
    input  reading_t rd,
    output seg_en_t  en
);
    logic show_hund, show_tens;

    always_comb begin
        show_hund = rd.half || (rd.hund != 4'd0);
        show_tens = show_hund || (rd.tens != 4'd0);
        en.minus  = rd.neg;
        if (rd.over) begin
            en.lead  = 1'b1;
            en.hund  = '0;
            en.tens  = '0;
            en.units = '0;
        end else begin
            en.lead  = rd.half;
            en.hund  = show_hund ? seg7_font(rd.hund) : '0;
            en.tens  = show_tens ? seg7_font(rd.tens) : '0;
            en.units = seg7_font(rd.units);
        end
    end
endmodule

// File: rtl/lcd_phase_drive.sv
module lcd_phase_drive
    import lcd_drv_pkg::*;
(
    input  logic              bp,
    input  logic              test,
    input  logic [LINE_N-1:0] en,
    output logic [LINE_N-1:0] line
);
    for (genvar i = 0; i < LINE_N; i++) begin : g_line
        assign line[i] = test ? 1'b1 : (en[i] ^ bp);
    end
endmodule

// File: rtl/lcd_ac_driver.sv
module lcd_ac_driver
    import lcd_drv_pkg::*;
#(
    parameter int BP_HALF = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] dig_units,
    input  logic [3:0] dig_tens,
    input  logic [3:0] dig_hund,
    input  logic       half_one,
    input  logic       negative,
    input  logic       overrange,
    input  logic       lamp_test,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hund,
    output logic       seg_lead,
    output logic       seg_minus,
    output logic       backplane
);
    reading_t          incoming;
    reading_t          latched;
    seg_en_t           enables;
    logic [LINE_N-1:0] lines;

    assign incoming = '{hund: dig_hund, tens: dig_tens, units: dig_units,
                        half: half_one, neg: negative, over: overrange};

    lcd_bp_gen #(.BP_HALF(BP_HALF)) u_bp (
        .clk (clk),
        .rst (rst),
        .bp  (backplane)
    );

    lcd_reading_reg u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (incoming),
        .q    (latched)
    );

    lcd_seg_map u_map (
        .rd (latched),
        .en (enables)
    );

    lcd_phase_drive u_drv (
        .bp   (backplane),
        .test (lamp_test),
        .en   (enables),
        .line (lines)
    );

    assign {seg_hund, seg_tens, seg_units, seg_lead, seg_minus} = lines;
endmodule

// File: rtl/lcd_ac_driver_chk.sv
module lcd_ac_driver_chk #(
    parameter int BP_HALF = 400
) (
    input logic       clk,
    input logic       rst,
    input logic       load,
    input logic       lamp_test,
    input logic [6:0] seg_units,
    input logic [6:0] seg_tens,
    input logic [6:0] seg_hund,
    input logic       seg_lead,
    input logic       seg_minus,
    input logic       backplane,
    input logic       shown_over,
    input logic       shown_neg
);
    localparam int AW = $clog2(BP_HALF + 2);
    localparam logic [AW-1:0] SAT = AW'(BP_HALF + 1);

    logic          bp_q;
    logic [AW-1:0] age;
    logic [22:0]   lit_pat;

    assign lit_pat = {seg_hund, seg_tens, seg_units, seg_lead, seg_minus} ^ {23{backplane}};

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q <= 1'b0;
            age  <= '0;
        end else begin
            bp_q <= backplane;
            if (backplane != bp_q) age <= '0;
            else if (age != SAT)   age <= age + 1'b1;
        end
    end

    // R1: backplane never holds a level too long, never toggles too early
    assert_bp_hold_R1: assert property (@(posedge clk) disable iff (rst)
        age <= AW'(BP_HALF));
    assert_bp_early_R1: assert property (@(posedge clk) disable iff (rst)
        (backplane != bp_q) |-> (age >= AW'(BP_HALF - 1)));

    // R9: lamp test forces every segment line high
    assert_lamp_all_on_R9: assert property (@(posedge clk) disable iff (rst)
        lamp_test |-> (&{seg_hund, seg_tens, seg_units, seg_lead, seg_minus}));

    // R8: without a load the lit pattern does not move
    assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !lamp_test && !$past(lamp_test)) |-> (lit_pat == $past(lit_pat)));

    // R7: overrange blanks lower digits and lights the leading one
    assert_over_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (!lamp_test && shown_over) |->
        (seg_units == {7{backplane}} && seg_tens == {7{backplane}} &&
         seg_hund == {7{backplane}} && seg_lead != backplane));

    // R6: minus line follows the held sign
    assert_minus_sign_R6: assert property (@(posedge clk) disable iff (rst)
        !lamp_test |-> ((seg_minus != backplane) == shown_neg));
endmodule

bind lcd_ac_driver lcd_ac_driver_chk #(.BP_HALF(BP_HALF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .lamp_test  (lamp_test),
    .seg_units  (seg_units),
    .seg_tens   (seg_tens),
    .seg_hund   (seg_hund),
    .seg_lead   (seg_lead),
    .seg_minus  (seg_minus),
    .backplane  (backplane),
    .shown_over (latched.over),
    .shown_neg  (latched.neg)
);

// File: tb/lcd_ac_driver_test.sv
`timescale 1ns/1ps
module lcd_ac_driver_test;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [3:0] dig_units = '0, dig_tens = '0, dig_hund = '0;
    logic half_one = 1'b0, negative = 1'b0, overrange = 1'b0, lamp_test = 1'b0;
    logic [6:0] seg_units, seg_tens, seg_hund;
    logic seg_lead, seg_minus, backplane;

    int errors = 0;
    int checks = 0;
    int edges  = 0;
    bit done   = 0;

    // held model reading
    int  m_h = 0, m_t = 0, m_u = 0;
    bit  m_half = 0, m_neg = 0, m_over = 0;

    always #2.5 clk = ~clk;

    lcd_ac_driver #(.BP_HALF(HALF)) uut (
        .clk(clk), .rst(rst), .load(load),
        .dig_units(dig_units), .dig_tens(dig_tens), .dig_hund(dig_hund),
        .half_one(half_one), .negative(negative), .overrange(overrange),
        .lamp_test(lamp_test),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
        .seg_lead(seg_lead), .seg_minus(seg_minus), .backplane(backplane)
    );

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    function automatic logic [6:0] font(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [22:0] expect_lit();
        logic [6:0] h, t, u;
        bit sh, st;
        if (m_over) return {21'b0, 1'b1, m_neg};
        sh = m_half || (m_h != 0);
        st = sh || (m_t != 0);
        h = sh ? font(m_h) : 7'h00;
        t = st ? font(m_t) : 7'h00;
        u = font(m_u);
        return {h, t, u, m_half, m_neg};
    endfunction

    task automatic check_out(input string req);
        logic exp_bp;
        logic [22:0] exp_v, act_v;
        exp_bp = logic'((edges / HALF) % 2);
        checks++;
        if (backplane !== exp_bp) begin
            errors++;
            $display("FAIL R1 (%s) backplane actual=%0b expected=%0b", req, backplane, exp_bp);
        end
        exp_v = lamp_test ? {23{1'b1}} : (expect_lit() ^ {23{exp_bp}});
        act_v = {seg_hund, seg_tens, seg_units, seg_lead, seg_minus};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s lines actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic drive(input int h, input int t, input int u,
                         input bit hf, input bit ng, input bit ov);
        dig_hund = 4'(h); dig_tens = 4'(t); dig_units = 4'(u);
        half_one = hf; negative = ng; overrange = ov;
    endtask

    task automatic load_reading(input int h, input int t, input int u,
                                input bit hf, input bit ng, input bit ov);
        drive(h, t, u, hf, ng, ov);
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        m_h = h; m_t = t; m_u = u; m_half = hf; m_neg = ng; m_over = ov;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset shows positive zero, units only
        check_out("R10");

        // R1: backplane over several periods with reset reading
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            check_out("R1");
        end

        // R2 R3 R4 R5 R6: full sweep of in-range readings
        for (int hf = 0; hf < 2; hf++)
            for (int ng = 0; ng < 2; ng++)
                for (int h = 0; h < 10; h++)
                    for (int t = 0; t < 10; t++)
                        for (int u = 0; u < 10; u++) begin
                            load_reading(h, t, u, bit'(hf), bit'(ng), 1'b0);
                            check_out("R2_R3_R4_R5_R6");
                        end

        // R3: unused codes light nothing
        for (int c = 10; c < 16; c++) begin
            load_reading(c, c, c, 1'b1, 1'b0, 1'b0);
            check_out("R3");
            load_reading(0, 0, c, 1'b0, 1'b1, 1'b0);
            check_out("R3");
        end

        // R7: overrange with assorted digits and signs
        for (int ng = 0; ng < 2; ng++)
            for (int k = 0; k < 10; k++) begin
                load_reading(k, 9 - k, k, bit'(k % 2), bit'(ng), 1'b1);
                check_out("R7");
            end

        // R8: inputs change without load, display holds
        load_reading(4, 5, 6, 1'b1, 1'b0, 1'b0);
        drive(9, 9, 9, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 2 * HALF + 1; i++) begin
            @(negedge clk);
            check_out("R8");
        end
        load_reading(0, 0, 7, 1'b0, 1'b1, 1'b0);
        check_out("R8");

        // R9: lamp test constant high, backplane running, then release
        lamp_test = 1'b1;
        for (int i = 0; i < 2 * HALF + 1; i++) begin
            @(negedge clk);
            check_out("R9");
        end
        lamp_test = 1'b0;
        @(negedge clk);
        check_out("R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule